// File: doc/BRIEF.md
# Bus Monitor Message DMA Sequencer

This block moves the contents of one monitored serial-bus message into system memory. A bus decoder ahead of it reports events on a simple interface: a valid command (with the captured command word and a flag saying the terminal address is being watched), each data word, the status word, the end of the message and an error. The block turns every event into a short, fixed series of memory accesses. It requests the memory bus from an arbiter, waits for the grant, performs the accesses on a plain master port that acknowledges each access with a ready signal, and then releases the bus.

Each message is described by a four-word command block in memory. Word 0 holds control and, later, the completion status. Word 1 receives the command word. Word 2 holds the address of the data list. Word 3 receives the address of the next command block. Data words are stored one after another starting at the data list address. The status word goes into the next free location after them. When the message closes, the block writes its completion status and the next block address, then moves on to that next block. A one-entry buffer absorbs a word that arrives while a transfer is still in progress. An error on the bus raises a request to the interrupt logic and freezes the transfer engine until software resumes it.

Top module: `bmon_dma_seq`

## Requirements
- R1: A command is accepted only when `mon_enable`=1, `ev_addr_match`=1 and no message is active. `cmd_strobe` is then high for exactly the one cycle after the command cycle. If the command is not accepted, there is no strobe and no memory access.
- R2: For an accepted command the block requests the bus with `dma_burst`=1. While it holds the grant it reads block+0, writes the command word to block+1 and reads block+2, in that order. The word read from block+2 becomes the data pointer.
- R3: Each data word received during an active message causes a single request (`dma_burst`=0) and one write of that word to the data pointer. The pointer then advances by one and wraps modulo 2^AW. This happens whatever the content of the command word.
- R4: A status word received during an active message causes a single request and one write to the current data pointer, which is the address after the last data word. The pointer does not advance.
- R5: At message end the block requests a burst. It writes the completion word to block+0 and then writes block+4, zero-extended, to block+3. The next message uses block+4. In the completion word, bit DW-1 is 1, bit DW-2 is 1 if an error was seen in the message, the low CNT_W bits hold the number of data words stored, and all other bits are 0.
- R6: A memory access occurs only while `dma_gnt` is high. An access holds its address and write data steady until `mem_rdy`. `dma_burst` stays constant for as long as `dma_req` stays high.
- R7: Data, status, message-end and error events that arrive while no message is active cause no memory access and no interrupt request.
- R8: A data or status word that arrives while a transfer is in progress is buffered and written later, in arrival order. A word that arrives while the buffer is still occupied is dropped and sets `ovf_err`. `ovf_err` stays set until the next accepted command clears it.
- R9: An error event during an active message sets `irq_req`. From then on no new transfer starts until a `resume` pulse clears `irq_req`, after which pending work continues. The completion word records the error.
- R10: During and right after reset `dma_req`, `mem_rd`, `mem_wr`, `cmd_strobe`, `irq_req` and `ovf_err` are 0. The first command block is at `base_ptr`, which is sampled while reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mon_enable | input | 1 | Monitoring enabled |
| base_ptr | input | AW | First command block address, sampled in reset |
| ev_cmd_valid | input | 1 | Valid command event |
| ev_cmd_word | input | DW | Captured command word |
| ev_addr_match | input | 1 | Command addresses a monitored terminal |
| ev_data_valid | input | 1 | Data word event |
| ev_data_word | input | DW | Received data word |
| ev_stat_valid | input | 1 | Status word event |
| ev_stat_word | input | DW | Received status word |
| ev_msg_end | input | 1 | Message complete event |
| ev_error | input | 1 | Message error event |
| resume | input | 1 | Clears the error hold |
| cmd_strobe | output | 1 | One-cycle pulse on an accepted command |
| irq_req | output | 1 | Request to the interrupt block; high while held |
| ovf_err | output | 1 | Event buffer overflow flag |
| dma_req | output | 1 | Memory bus request |
| dma_burst | output | 1 | Request is a burst |
| dma_gnt | input | 1 | Memory bus grant |
| mem_rd | output | 1 | Read access |
| mem_wr | output | 1 | Write access |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_rdy | input | 1 | Access acknowledge |

## Verification
The bench builds the block with AW=8, DW=16 and CNT_W=8. The 8-bit address space makes a 256-word memory model practical and lets a data list placed at 0xFE cross the wrap to 0x00 within three words. Because DW is wider than AW, the upper bits of the pointer word are exercised as ignored, and the next-block address is checked as zero-extended in the tail write. Back-to-back data events show both sides of the one-entry buffer. A word that arrives during a command burst is held and written after it, and a third word in a row overflows the buffer.

// File: rtl/bmon_dma_pkg.sv
package bmon_dma_pkg;
   typedef enum logic [1:0] {JOB_CMD, JOB_DATA, JOB_STAT, JOB_END} job_e;
   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XFER} seq_st_e;
   // command block word offsets; the layout is decoded by software
   localparam int OFS_CTRL  = 0;
   localparam int OFS_CMD   = 1;
   localparam int OFS_DLIST = 2;
   localparam int OFS_NEXT  = 3;
   localparam int BLK_WORDS = 4;
endpackage

// File: rtl/bmon_evt_buf.sv
module bmon_evt_buf #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_ovf,
   input  logic          data_v,
   input  logic [DW-1:0] data_w,
   input  logic          stat_v,
   input  logic [DW-1:0] stat_w,
   input  logic          pop,
   output logic          valid,
   output logic          is_stat,
   output logic [DW-1:0] word,
   output logic          ovf
);
   logic push, take, lost;

   assign push = data_v || stat_v;
   assign take = push && (!valid || pop);
   assign lost = (push && valid && !pop) || (data_v && stat_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         is_stat <= 1'b0;
         word    <= '0;
         ovf     <= 1'b0;
      end else begin
         if (take) begin
            valid   <= 1'b1;
            is_stat <= !data_v;
            word    <= data_v ? data_w : stat_w;
         end else if (pop) begin
            valid <= 1'b0;
         end
         if (clr_ovf)   ovf <= 1'b0;
         else if (lost) ovf <= 1'b1;
      end
   end

   // R8
   pop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> valid);
endmodule

// File: rtl/bmon_ptr_regs.sv
module bmon_ptr_regs #(
   parameter int AW    = 16,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    base_ptr,
   input  logic             clr_cnt,
   input  logic             ld_dptr,
   input  logic [AW-1:0]    dptr_val,
   input  logic             inc_dptr,
   input  logic             adv_blk,
   output logic [AW-1:0]    blk_ptr,
   output logic [AW-1:0]    dptr,
   output logic [CNT_W-1:0] wcount
);
   import bmon_dma_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_ptr <= base_ptr;
         dptr    <= '0;
         wcount  <= '0;
      end else begin
         if (adv_blk)       blk_ptr <= blk_ptr + AW'(BLK_WORDS);
         if (ld_dptr)       dptr <= dptr_val;
         else if (inc_dptr) dptr <= dptr + 1'b1;
         if (clr_cnt)       wcount <= '0;
         else if (inc_dptr) wcount <= wcount + 1'b1;
      end
   end
endmodule

// File: rtl/bmon_seq_fsm.sv
module bmon_seq_fsm #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_acc,
   input  logic [DW-1:0] cmd_word_in,
   input  logic          end_ev,
   input  logic          err_ev,
   input  logic          resume,
   input  logic          buf_valid,
   input  logic          buf_is_stat,
   input  logic [DW-1:0] buf_word,
   input  logic [AW-1:0] blk_ptr,
   input  logic [AW-1:0] dptr,
   input  logic [DW-1:0] stat_word,
   input  logic          dma_gnt,
   input  logic          mem_rdy,
   output logic          buf_pop,
   output logic          msg_active,
   output logic          halted,
   output logic          err_seen,
   output logic          dma_req,
   output logic          dma_burst,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          ld_dptr,
   output logic          inc_dptr,
   output logic          adv_blk
);
   import bmon_dma_pkg::*;

   seq_st_e       st;
   job_e          job;
   logic [1:0]    step, last_step;
   logic          cmd_pend, end_pend, done;
   logic [DW-1:0] cmd_word, xfer_word;
   logic          rd_c, wr_c;
   logic [AW-1:0] addr_c;
   logic [DW-1:0] wd_c;

   assign last_step = (job == JOB_CMD) ? 2'd2 : (job == JOB_END) ? 2'd1 : 2'd0;
   assign done      = (st == ST_XFER) && mem_rdy;
   assign buf_pop   = (st == ST_IDLE) && !halted && !cmd_pend && buf_valid;
   assign ld_dptr   = done && (job == JOB_CMD) && (step == 2'd2);
   assign inc_dptr  = done && (job == JOB_DATA);
   assign adv_blk   = done && (job == JOB_END) && (step == 2'd1);
   assign dma_req   = (st != ST_IDLE);
   assign dma_burst = (st != ST_IDLE) && ((job == JOB_CMD) || (job == JOB_END));

   always_comb begin
      rd_c   = 1'b0;
      wr_c   = 1'b1;
      addr_c = dptr;
      wd_c   = xfer_word;
      case (job)
         JOB_CMD: begin
            case (step)
               2'd0:    begin rd_c = 1'b1; wr_c = 1'b0; addr_c = blk_ptr + AW'(OFS_CTRL); end
               2'd1:    begin addr_c = blk_ptr + AW'(OFS_CMD); wd_c = cmd_word; end
               default: begin rd_c = 1'b1; wr_c = 1'b0; addr_c = blk_ptr + AW'(OFS_DLIST); end
            endcase
         end
         JOB_END: begin
            if (step == 2'd0) begin
               addr_c = blk_ptr + AW'(OFS_CTRL);
               wd_c   = stat_word;
            end else begin
               addr_c = blk_ptr + AW'(OFS_NEXT);
               wd_c   = DW'(blk_ptr + AW'(BLK_WORDS));
            end
         end
         default: ;
      endcase
   end

   assign mem_rd    = (st == ST_XFER) && rd_c;
   assign mem_wr    = (st == ST_XFER) && wr_c;
   assign mem_addr  = addr_c;
   assign mem_wdata = wd_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         job        <= JOB_CMD;
         step       <= '0;
         cmd_pend   <= 1'b0;
         end_pend   <= 1'b0;
         msg_active <= 1'b0;
         halted     <= 1'b0;
         err_seen   <= 1'b0;
         cmd_word   <= '0;
         xfer_word  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               step <= '0;
               if (!halted) begin
                  if (cmd_pend) begin
                     job      <= JOB_CMD;
                     cmd_pend <= 1'b0;
                     st       <= ST_WAIT;
                  end else if (buf_valid) begin
                     job       <= buf_is_stat ? JOB_STAT : JOB_DATA;
                     xfer_word <= buf_word;
                     st        <= ST_WAIT;
                  end else if (end_pend) begin
                     job      <= JOB_END;
                     end_pend <= 1'b0;
                     st       <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: if (dma_gnt) st <= ST_XFER;
            default: begin
               if (mem_rdy) begin
                  if (step == last_step) begin
                     st <= ST_IDLE;
                     if (job == JOB_END) msg_active <= 1'b0;
                  end else begin
                     step <= step + 1'b1;
                  end
               end
            end
         endcase
         if (resume) halted <= 1'b0;
         if (err_ev && msg_active) begin
            halted   <= 1'b1;
            err_seen <= 1'b1;
         end
         if (end_ev && msg_active) end_pend <= 1'b1;
         if (cmd_acc) begin
            cmd_pend   <= 1'b1;
            cmd_word   <= cmd_word_in;
            msg_active <= 1'b1;
            err_seen   <= 1'b0;
         end
      end
   end

   // R6
   access_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> dma_gnt);
   // R6
   access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !mem_rdy) |=>
      ((mem_rd || mem_wr) && $stable(mem_addr) && $stable(mem_wdata)));
   // R6
   burst_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |=> (!dma_req || $stable(dma_burst)));
   // R9
   halt_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !dma_req) |=> !dma_req);
endmodule

// File: rtl/bmon_dma_seq.sv
module bmon_dma_seq #(
   parameter int AW    = 16,
   parameter int DW    = 16,
   parameter int CNT_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mon_enable,
   input  logic [AW-1:0] base_ptr,
   input  logic          ev_cmd_valid,
   input  logic [DW-1:0] ev_cmd_word,
   input  logic          ev_addr_match,
   input  logic          ev_data_valid,
   input  logic [DW-1:0] ev_data_word,
   input  logic          ev_stat_valid,
   input  logic [DW-1:0] ev_stat_word,
   input  logic          ev_msg_end,
   input  logic          ev_error,
   input  logic          resume,
   output logic          cmd_strobe,
   output logic          irq_req,
   output logic          ovf_err,
   output logic          dma_req,
   output logic          dma_burst,
   input  logic          dma_gnt,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_rdy
);
   localparam int PAD_W = DW - 2 - CNT_W;

   if (AW > DW) begin : g_chk_aw
      $error("bmon_dma_seq: AW must not exceed DW");
   end
   if (AW < 3) begin : g_chk_aw_min
      $error("bmon_dma_seq: AW too small for a command block");
   end
   if (CNT_W + 2 > DW) begin : g_chk_cnt
      $error("bmon_dma_seq: CNT_W + 2 must fit in DW");
   end

   logic             msg_active, halted, err_seen, cmd_acc;
   logic             buf_valid, buf_is_stat, buf_pop;
   logic [DW-1:0]    buf_word, stat_word;
   logic [AW-1:0]    blk_ptr, dptr;
   logic [CNT_W-1:0] wcount;
   logic             ld_dptr, inc_dptr, adv_blk;

   assign cmd_acc = ev_cmd_valid && mon_enable && ev_addr_match && !msg_active;
   assign irq_req = halted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_strobe <= 1'b0;
      else        cmd_strobe <= cmd_acc;
   end

   if (PAD_W > 0) begin : g_stat_pad
      assign stat_word = {1'b1, err_seen, {PAD_W{1'b0}}, wcount};
   end else begin : g_stat_full
      assign stat_word = {1'b1, err_seen, wcount};
   end

   if (DW > AW) begin : g_rdata_hi
      logic unused_rdata_hi;
      assign unused_rdata_hi = ^mem_rdata[DW-1:AW];
   end

   bmon_evt_buf #(.DW(DW)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr_ovf(cmd_acc),
      .data_v(ev_data_valid && msg_active), .data_w(ev_data_word),
      .stat_v(ev_stat_valid && msg_active), .stat_w(ev_stat_word),
      .pop(buf_pop), .valid(buf_valid), .is_stat(buf_is_stat),
      .word(buf_word), .ovf(ovf_err)
   );

   bmon_ptr_regs #(.AW(AW), .CNT_W(CNT_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .base_ptr(base_ptr), .clr_cnt(cmd_acc),
      .ld_dptr(ld_dptr), .dptr_val(mem_rdata[AW-1:0]), .inc_dptr(inc_dptr),
      .adv_blk(adv_blk), .blk_ptr(blk_ptr), .dptr(dptr), .wcount(wcount)
   );

   bmon_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd_acc(cmd_acc), .cmd_word_in(ev_cmd_word),
      .end_ev(ev_msg_end), .err_ev(ev_error), .resume(resume),
      .buf_valid(buf_valid), .buf_is_stat(buf_is_stat), .buf_word(buf_word),
      .blk_ptr(blk_ptr), .dptr(dptr), .stat_word(stat_word),
      .dma_gnt(dma_gnt), .mem_rdy(mem_rdy), .buf_pop(buf_pop),
      .msg_active(msg_active), .halted(halted), .err_seen(err_seen),
      .dma_req(dma_req), .dma_burst(dma_burst), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .ld_dptr(ld_dptr), .inc_dptr(inc_dptr), .adv_blk(adv_blk)
   );

   // R1
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_strobe |=> !cmd_strobe);
endmodule

// File: tb/test_bmon_dma_seq.sv
`timescale 1ns/1ps
module test_bmon_dma_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mon_enable = 1'b0;
   logic [7:0]  base_ptr = 8'h10;
   logic        ev_cmd_valid = 1'b0, ev_addr_match = 1'b0;
   logic [15:0] ev_cmd_word = '0, ev_data_word = '0, ev_stat_word = '0;
   logic        ev_data_valid = 1'b0, ev_stat_valid = 1'b0;
   logic        ev_msg_end = 1'b0, ev_error = 1'b0, resume = 1'b0;
   logic        cmd_strobe, irq_req, ovf_err, dma_req, dma_burst;
   logic        dma_gnt = 1'b0, mem_rdy = 1'b0;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_addr;
   logic [15:0] mem_wdata, mem_rdata = '0;

   always #4 clk = ~clk;

   bmon_dma_seq #(.AW(8), .DW(16), .CNT_W(8)) i_bmon_dma_seq (
      .clk(clk), .rst_n(rst_n), .mon_enable(mon_enable), .base_ptr(base_ptr),
      .ev_cmd_valid(ev_cmd_valid), .ev_cmd_word(ev_cmd_word),
      .ev_addr_match(ev_addr_match), .ev_data_valid(ev_data_valid),
      .ev_data_word(ev_data_word), .ev_stat_valid(ev_stat_valid),
      .ev_stat_word(ev_stat_word), .ev_msg_end(ev_msg_end), .ev_error(ev_error),
      .resume(resume), .cmd_strobe(cmd_strobe), .irq_req(irq_req),
      .ovf_err(ovf_err), .dma_req(dma_req), .dma_burst(dma_burst),
      .dma_gnt(dma_gnt), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
   );

   typedef struct {
      bit          wr;
      logic [7:0]  addr;
      logic [15:0] data;
      bit          burst;
      string       req;
   } acc_t;

   acc_t        exp_q[$];
   logic [15:0] mem [0:255];
   int          checks = 0;
   int          errors = 0;
   bit          done_flag = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic expect_acc(input bit wr, input logic [7:0] a, input logic [15:0] d,
                             input bit burst, input string req);
      acc_t e;
      e.wr = wr; e.addr = a; e.data = d; e.burst = burst; e.req = req;
      exp_q.push_back(e);
   endtask

   // Reference memory, arbiter and per-clock comparison of every access
   always @(negedge clk) begin
      if (!rst_n) begin
         dma_gnt <= 1'b0;
         mem_rdy <= 1'b0;
      end else begin
         dma_gnt <= dma_req;
         if (mem_rd && mem_wr) check(1'b0, "R6", "read and write together", 1, 0);
         if (mem_rdy) begin
            mem_rdy <= 1'b0;
         end else if (mem_rd || mem_wr) begin
            check(dma_gnt, "R6", "access without grant", {31'b0, dma_gnt}, 1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R7", "unexpected access addr", {24'b0, mem_addr}, 0);
            end else begin
               acc_t e;
               e = exp_q.pop_front();
               check(mem_wr == e.wr, e.req, "access kind", {31'b0, mem_wr}, {31'b0, e.wr});
               check(mem_addr == e.addr, e.req, "access address", {24'b0, mem_addr}, {24'b0, e.addr});
               check(dma_burst == e.burst, e.req, "burst flag", {31'b0, dma_burst}, {31'b0, e.burst});
               if (e.wr) check(mem_wdata == e.data, e.req, "write data", {16'b0, mem_wdata}, {16'b0, e.data});
            end
            if (mem_wr) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
            mem_rdy <= 1'b1;
         end
      end
   end

   task automatic wait_quiet();
      int quiet = 0;
      while (quiet < 4) begin
         @(negedge clk);
         if (dma_req) quiet = 0;
         else quiet++;
      end
   endtask

   task automatic send_cmd(input logic [15:0] w, input bit match, input bit exp_strobe, input string req);
      @(negedge clk);
      ev_cmd_valid = 1'b1; ev_cmd_word = w; ev_addr_match = match;
      @(negedge clk);
      ev_cmd_valid = 1'b0; ev_addr_match = 1'b0;
      check(cmd_strobe == exp_strobe, req, "command strobe", {31'b0, cmd_strobe}, {31'b0, exp_strobe});
      @(negedge clk);
      check(cmd_strobe == 1'b0, "R1", "strobe width", {31'b0, cmd_strobe}, 0);
   endtask

   task automatic send_data(input logic [15:0] w);
      @(negedge clk);
      ev_data_valid = 1'b1; ev_data_word = w;
      @(negedge clk);
      ev_data_valid = 1'b0;
   endtask

   task automatic send_stat(input logic [15:0] w);
      @(negedge clk);
      ev_stat_valid = 1'b1; ev_stat_word = w;
      @(negedge clk);
      ev_stat_valid = 1'b0;
   endtask

   task automatic send_end();
      @(negedge clk);
      ev_msg_end = 1'b1;
      @(negedge clk);
      ev_msg_end = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "WDOG", "watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
      mem[8'h10] = 16'h5555; mem[8'h12] = 16'h0040;
      mem[8'h16] = 16'hA3FE; mem[8'h1A] = 16'h0060; mem[8'h1E] = 16'h0080;
      repeat (3) @(negedge clk);
      // R10 reset state
      check(!dma_req && !mem_rd && !mem_wr, "R10", "bus idle in reset", {29'b0, dma_req, mem_rd, mem_wr}, 0);
      check(!cmd_strobe && !irq_req && !ovf_err, "R10", "flags in reset", {29'b0, cmd_strobe, irq_req, ovf_err}, 0);
      rst_n = 1'b1;
      base_ptr = 8'h00;
      repeat (2) @(negedge clk);
      check(!dma_req && !irq_req && !ovf_err, "R10", "idle after reset", {29'b0, dma_req, irq_req, ovf_err}, 0);
      mon_enable = 1'b1;

      // Message A at 0x10: R2, R3, R4, R5
      expect_acc(0, 8'h10, 0, 1, "R2"); expect_acc(1, 8'h11, 16'h1234, 1, "R2");
      expect_acc(0, 8'h12, 0, 1, "R2");
      send_cmd(16'h1234, 1, 1, "R1");
      wait_quiet();
      for (int i = 0; i < 3; i++) begin
         expect_acc(1, 8'h40 + 8'(i), 16'h0A01 + 16'(i), 0, "R3");
         send_data(16'h0A01 + 16'(i));
         wait_quiet();
      end
      expect_acc(1, 8'h43, 16'h0800, 0, "R4");
      send_stat(16'h0800);
      wait_quiet();
      expect_acc(1, 8'h10, 16'h8003, 1, "R5"); expect_acc(1, 8'h13, 16'h0014, 1, "R5");
      send_end();
      wait_quiet();
      check(exp_q.size() == 0, "R5", "message A accesses outstanding", exp_q.size(), 0);

      // Rejected commands and events outside a message: R1, R7
      mon_enable = 1'b0;
      send_cmd(16'h1111, 1, 0, "R1");
      send_data(16'hDEAD); send_stat(16'hBEEF);
      @(negedge clk); ev_error = 1'b1; @(negedge clk); ev_error = 1'b0;
      send_end();
      mon_enable = 1'b1;
      send_cmd(16'h2222, 0, 0, "R1");
      send_data(16'hDEAD);
      repeat (20) @(negedge clk);
      check(!dma_req && !irq_req, "R7", "no request outside a message", {30'b0, dma_req, irq_req}, 0);

      // Message B at 0x14: pointer wrap R3, error hold R9
      expect_acc(0, 8'h14, 0, 1, "R2"); expect_acc(1, 8'h15, 16'h0C21, 1, "R2");
      expect_acc(0, 8'h16, 0, 1, "R2");
      send_cmd(16'h0C21, 1, 1, "R1");
      wait_quiet();
      for (int i = 0; i < 3; i++) begin
         expect_acc(1, 8'hFE + 8'(i), 16'h0B01 + 16'(i), 0, "R3");
         send_data(16'h0B01 + 16'(i));
         wait_quiet();
      end
      @(negedge clk); ev_error = 1'b1;
      @(negedge clk); ev_error = 1'b0;
      check(irq_req == 1'b1, "R9", "interrupt request after error", {31'b0, irq_req}, 1);
      send_stat(16'h0900);
      send_end();
      repeat (30) @(negedge clk);
      check(!dma_req, "R9", "no transfer while held", {31'b0, dma_req}, 0);
      check(irq_req == 1'b1, "R9", "request stays until resume", {31'b0, irq_req}, 1);
      expect_acc(1, 8'h01, 16'h0900, 0, "R4");
      expect_acc(1, 8'h14, 16'hC003, 1, "R9"); expect_acc(1, 8'h17, 16'h0018, 1, "R5");
      @(negedge clk); resume = 1'b1;
      @(negedge clk); resume = 1'b0;
      check(irq_req == 1'b0, "R9", "resume clears request", {31'b0, irq_req}, 0);
      wait_quiet();
      check(exp_q.size() == 0, "R9", "message B accesses outstanding", exp_q.size(), 0);

      // Message C at 0x18: overflow R8
      expect_acc(0, 8'h18, 0, 1, "R2"); expect_acc(1, 8'h19, 16'h4321, 1, "R2");
      expect_acc(0, 8'h1A, 0, 1, "R2");
      send_cmd(16'h4321, 1, 1, "R1");
      wait_quiet();
      expect_acc(1, 8'h60, 16'h0C01, 0, "R8"); expect_acc(1, 8'h61, 16'h0C02, 0, "R8");
      @(negedge clk); ev_data_valid = 1'b1; ev_data_word = 16'h0C01;
      @(negedge clk); ev_data_word = 16'h0C02;
      @(negedge clk); ev_data_word = 16'h0C03;
      @(negedge clk); ev_data_valid = 1'b0;
      wait_quiet();
      check(ovf_err == 1'b1, "R8", "overflow flag", {31'b0, ovf_err}, 1);
      expect_acc(1, 8'h18, 16'h8002, 1, "R5"); expect_acc(1, 8'h1B, 16'h001C, 1, "R5");
      send_end();
      wait_quiet();
      check(exp_q.size() == 0, "R8", "message C accesses outstanding", exp_q.size(), 0);
      check(ovf_err == 1'b1, "R8", "overflow flag held", {31'b0, ovf_err}, 1);

      // Message D at 0x1C: data word buffered behind the command burst, R8
      expect_acc(0, 8'h1C, 0, 1, "R2"); expect_acc(1, 8'h1D, 16'h3333, 1, "R2");
      expect_acc(0, 8'h1E, 0, 1, "R2"); expect_acc(1, 8'h80, 16'hAAAA, 0, "R8");
      @(negedge clk); ev_cmd_valid = 1'b1; ev_cmd_word = 16'h3333; ev_addr_match = 1'b1;
      @(negedge clk); ev_cmd_valid = 1'b0; ev_addr_match = 1'b0;
      ev_data_valid = 1'b1; ev_data_word = 16'hAAAA;
      check(cmd_strobe == 1'b1, "R1", "command strobe D", {31'b0, cmd_strobe}, 1);
      check(ovf_err == 1'b0, "R8", "overflow cleared by command", {31'b0, ovf_err}, 0);
      @(negedge clk); ev_data_valid = 1'b0;
      wait_quiet();
      expect_acc(1, 8'h1C, 16'h8001, 1, "R5"); expect_acc(1, 8'h1F, 16'h0020, 1, "R5");
      send_end();
      wait_quiet();
      check(exp_q.size() == 0, "R5", "message D accesses outstanding", exp_q.size(), 0);
      check(mem[8'h1F] == 16'h0020, "R5", "next block link in memory", {16'b0, mem[8'h1F]}, 32'h20);
      finish_run();
   end
endmodule